// File: doc/BRIEF.md
# Staged PLL Divider Register Bank

This block is the software-visible control point for one clock synthesizer. It holds three divider settings: an input (reference) divider, a feedback divider and an output divider. Software programs them over a simple 32-bit register port. Each divider word carries a low-time count, a high-time count, an odd-ratio edge flag, a bypass flag and a hold flag.

A write with the hold flag set only stages the word in a shadow copy. A write with the hold flag clear moves all three shadow copies, including the word just written, into the active settings on one clock edge. This means the synthesizer never runs with a partly updated ratio.

Every commit drops the reported lock for a fixed relock window. After the window, the lock report follows the lock input of the synthesizer. The commit also evaluates the new settings. If any divider that is not bypassed has a zero high or low time, an error flag is set. Lock and error are read from a status word that has its own address, outside the divider window.

Top module: `pll_divider_regbank`

## Requirements
- R1: The divider words sit at byte offsets 0x0 (input), 0x4 (feedback) and 0x8 (output). A read of one of these offsets returns that word's active value. Any other offset in the window 0x000–0x00F, and any other address apart from the status address, reads as zero and ignores writes.
- R2: Each divider word has these fields: low time in bits 5:0, high time in bits 11:6, edge in bit 12, bypass in bit 13 and hold (no-update) in bit 14. Bits 31:15 always read as zero, and writing them has no effect.
- R3: A divider write with bit 14 set changes only that word's shadow. No active word, no divider output and no read value changes.
- R4: A divider write with bit 14 clear copies all three shadows into the active words on the same edge, with the written word taking the new data. The new values appear on the divider outputs and in read-back one cycle after the request.
- R5: The status word is at address STAT_ADDR (default 0x100). Bit 0 is lock, bit 1 is error, and all other bits are zero. Writes to the status word are ignored.
- R6: A commit pulses `relock_start` for one cycle and forces lock to 0 for RELOCK_CYCLES cycles. After that, lock equals `pll_lock_in`.
- R7: A commit sets error when any word in the committed set has bypass clear and a zero low time or a zero high time. A later commit with no such word clears error. Error changes only on a commit.
- R8: After reset, every active and shadow word equals 0x2000 (bypass, divide by one). Error is 0 and no relock wait is pending.
- R9: A read request is answered exactly one cycle later by `rsp_valid` and `rsp_rdata`. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| pll_lock_in | input | 1 | Lock indication from the synthesizer |
| in_div_word | output | 32 | Active input divider word |
| fb_div_word | output | 32 | Active feedback divider word |
| out_div_word | output | 32 | Active output divider word |
| relock_start | output | 1 | One-cycle pulse when a new divider set is applied |
| lock_o | output | 1 | Reported lock |
| error_o | output | 1 | Reported configuration error |

## Verification
The bench stages the input and feedback words and checks that neither the outputs nor read-back move until the hold-clear write. A design that applied staged words early would show the new ratio one write too soon. It commits from the input slot rather than the output slot, to catch a design that only commits on the output word, and it counts the relock window to the exact cycle, where an off-by-one timer would report lock early or late. It also checks the following:
- Writes to an unmapped offset and to the status word: a design that decoded too loosely would trigger a commit or corrupt a word.
- A bypassed word with zero times: a design that ignored bypass when flagging errors would raise a false error.
- Reserved upper bits: a design that stored them would read them back as set.

// File: rtl/pll_rb_pkg.sv
package pll_rb_pkg;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 15;
  localparam int TIME_W    = 6;
  localparam int LOW_LSB   = 0;
  localparam int HIGH_LSB  = 6;
  localparam int EDGE_BIT  = 12;
  localparam int BYP_BIT   = 13;
  localparam int HOLD_BIT  = 14;
  localparam int NUM_DIV   = 3;
  localparam int IDX_W     = 2;

  localparam logic [FIELD_W-1:0] DIV_RESET = 15'h2000;

  typedef enum logic [IDX_W-1:0] {
    SLOT_IN  = 2'd0,
    SLOT_FB  = 2'd1,
    SLOT_OUT = 2'd2
  } div_slot_e;

  // A non-bypassed divider needs both phases to be at least one cycle long.
  function automatic logic div_fault(input logic [FIELD_W-1:0] w);
    logic zero_low;
    logic zero_high;
    zero_low  = (w[LOW_LSB +: TIME_W] == '0);
    zero_high = (w[HIGH_LSB +: TIME_W] == '0);
    return !w[BYP_BIT] && (zero_low || zero_high);
  endfunction
endpackage

// File: rtl/pll_rb_decode.sv
module pll_rb_decode
  import pll_rb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int STAT_ADDR = 'h100
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              hold_bit,
  output logic [NUM_DIV-1:0] slot_wr,
  output logic [NUM_DIV-1:0] slot_rd,
  output logic              stat_rd,
  output logic              commit
);
  logic             in_cfg_win;
  logic [IDX_W-1:0] idx;
  logic             is_wr;
  logic             is_rd;

  always_comb begin
    in_cfg_win = (req_addr[ADDR_W-1:4] == '0) && (req_addr[1:0] == 2'b00);
    idx        = req_addr[3:2];
    is_wr      = req_valid && req_write;
    is_rd      = req_valid && !req_write;
    stat_rd    = is_rd && (req_addr == ADDR_W'(STAT_ADDR));
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_sel
    logic hit;
    assign hit        = in_cfg_win && (idx == IDX_W'(i));
    assign slot_wr[i] = is_wr && hit;
    assign slot_rd[i] = is_rd && hit;
  end

  assign commit = (|slot_wr) && !hold_bit;

  // R1: at most one divider slot is addressed per request
  always_comb begin
    assert_one_slot_R1: assert ($onehot0(slot_wr) && $onehot0(slot_rd));
  end
endmodule

// File: rtl/pll_rb_div_slot.sv
module pll_rb_div_slot
  import pll_rb_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RESET_VAL = DIV_RESET
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               commit,
  output logic [FIELD_W-1:0] active_q,
  output logic               fault_next
);
  logic [FIELD_W-1:0] shadow_q;
  logic [FIELD_W-1:0] shadow_d;
  logic [FIELD_W-1:0] active_d;
  logic               shadow_en;
  logic               active_en;

  always_comb begin
    shadow_en  = wr_en;
    active_en  = commit;
    shadow_d   = wr_en ? wr_data : shadow_q;
    active_d   = shadow_d;
    fault_next = div_fault(shadow_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RESET_VAL;
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= RESET_VAL;
    end else if (active_en) begin
      active_q <= active_d;
    end
  end

  // R3: the active word only moves on a commit
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));

  // R4: a committing write to this slot lands directly in the active word
  assert_commit_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_en) |=> (active_q == $past(wr_data)));
endmodule

// File: rtl/pll_rb_lock_timer.sv
module pll_rb_lock_timer #(
  parameter int RELOCK_CYCLES = 5000,
  localparam int CNT_W = $clog2(RELOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lock_in,
  output logic locked
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             busy;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = start || busy;
    if (start) begin
      cnt_d = CNT_W'(RELOCK_CYCLES);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    locked = !busy && lock_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R6: lock is withdrawn right after a new setting is applied
  assert_relock_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !locked);
endmodule

// File: rtl/pll_divider_regbank.sv
module pll_divider_regbank
  import pll_rb_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int STAT_ADDR     = 'h100,
  parameter int RELOCK_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              pll_lock_in,
  output logic [31:0]       in_div_word,
  output logic [31:0]       fb_div_word,
  output logic [31:0]       out_div_word,
  output logic              relock_start,
  output logic              lock_o,
  output logic              error_o
);
  localparam int PAD_W = WORD_W - FIELD_W;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  logic [NUM_DIV-1:0] slot_wr;
  logic [NUM_DIV-1:0] slot_rd;
  logic               stat_rd;
  logic               commit;

  pll_rb_decode #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR)
  ) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .hold_bit  (req_wdata[HOLD_BIT]),
    .slot_wr   (slot_wr),
    .slot_rd   (slot_rd),
    .stat_rd   (stat_rd),
    .commit    (commit)
  );

  logic [FIELD_W-1:0] active [NUM_DIV];
  logic [NUM_DIV-1:0] fault_next;

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_slot
    pll_rb_div_slot #(
      .RESET_VAL (DIV_RESET)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_s_n),
      .wr_en      (slot_wr[i]),
      .wr_data    (req_wdata[FIELD_W-1:0]),
      .commit     (commit),
      .active_q   (active[i]),
      .fault_next (fault_next[i])
    );
  end

  // commit pulse and error flag
  logic commit_q;
  logic err_q;
  logic err_d;
  logic err_en;

  always_comb begin
    err_en = commit;
    err_d  = |fault_next;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      commit_q <= 1'b0;
    end else begin
      commit_q <= commit;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  logic locked;

  pll_rb_lock_timer #(
    .RELOCK_CYCLES (RELOCK_CYCLES)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (commit),
    .lock_in (pll_lock_in),
    .locked  (locked)
  );

  // read response path
  logic        rsp_valid_q;
  logic        rsp_valid_d;
  logic [31:0] rsp_data_q;
  logic [31:0] rsp_data_d;

  always_comb begin
    rsp_valid_d = stat_rd || (|slot_rd);
    rsp_data_d  = '0;
    if (stat_rd) begin
      rsp_data_d = {30'd0, err_q, locked};
    end
    for (int i = 0; i < NUM_DIV; i++) begin
      if (slot_rd[i]) begin
        rsp_data_d = {{PAD_W{1'b0}}, active[i]};
      end
    end
    // reads of unmapped addresses still answer, with zero data
    if (req_valid && !req_write) begin
      rsp_valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_rdata    = rsp_data_q;
  assign in_div_word  = {{PAD_W{1'b0}}, active[SLOT_IN]};
  assign fb_div_word  = {{PAD_W{1'b0}}, active[SLOT_FB]};
  assign out_div_word = {{PAD_W{1'b0}}, active[SLOT_OUT]};
  assign relock_start = commit_q;
  assign lock_o       = locked;
  assign error_o      = err_q;

  // R2: reserved bits never appear in read data
  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |-> (rsp_rdata[31:FIELD_W] == '0));

  // R7: error only changes when a new set is applied
  assert_err_on_commit_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !commit |=> $stable(err_q));

  // R9: each read is answered in the next cycle, writes are not
  assert_read_resp_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_no_write_resp_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R6: the relock pulse coincides with lock being withdrawn
  assert_pulse_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    relock_start |-> !lock_o);
endmodule

// File: tb/pll_divider_regbank_tb.sv
module pll_divider_regbank_tb;
  localparam int ADDR_W = 12;
  localparam int STAT   = 'h100;
  localparam int RELOCK = 40;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              pll_lock_in;
  logic [31:0]       in_div_word;
  logic [31:0]       fb_div_word;
  logic [31:0]       out_div_word;
  logic              relock_start;
  logic              lock_o;
  logic              error_o;

  int n_checks = 0;
  int n_errors = 0;

  pll_divider_regbank #(
    .ADDR_W        (ADDR_W),
    .STAT_ADDR     (STAT),
    .RELOCK_CYCLES (RELOCK)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .pll_lock_in  (pll_lock_in),
    .in_div_word  (in_div_word),
    .fb_div_word  (fb_div_word),
    .out_div_word (out_div_word),
    .relock_start (relock_start),
    .lock_o       (lock_o),
    .error_o      (error_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ratio n -> word; hold=1 sets bit 14 (R2 field layout)
  function automatic logic [31:0] enc(input int n, input bit hold);
    logic [31:0] w;
    w = '0;
    w[5:0]  = 6'((n + 1) / 2);
    w[11:6] = 6'(n / 2);
    w[12]   = 1'(n % 2);
    w[13]   = (n == 1);
    w[14]   = hold;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d,
                    output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                        input string tag);
    logic [31:0] d;
    logic v;
    rd(a, d, v);
    chk(v && d == exp, tag, d, exp);
  endtask

  task automatic wait_settle;
    repeat (RELOCK + 2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(in_div_word == 32'h2000, "R8 in reset", in_div_word, 32'h2000);
    chk(fb_div_word == 32'h2000 && out_div_word == 32'h2000, "R8 fb/out reset",
        fb_div_word ^ out_div_word, 32'h0);
    chk(!error_o && lock_o, "R8 err/lock reset", {error_o, lock_o}, 32'h1);
    rd_chk(12'h000, 32'h2000, "R1 R8 read in");
    rd_chk(12'h008, 32'h2000, "R1 R8 read out");
    rd_chk(STAT, 32'h1, "R5 status reset");
  endtask

  task automatic t_staged;
    logic v;
    wr(12'h000, enc(2, 1));
    chk(in_div_word == 32'h2000, "R3 staged in not applied", in_div_word, 32'h2000);
    rd_chk(12'h000, 32'h2000, "R3 read after stage");
    wr(12'h004, enc(45, 1));
    chk(fb_div_word == 32'h2000 && lock_o, "R3 staged fb not applied", fb_div_word, 32'h2000);
    // R4: hold-clear write to output commits all three
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h008; req_wdata = enc(10, 0);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(in_div_word == enc(2, 1), "R4 in applied", in_div_word, enc(2, 1));
    chk(fb_div_word == enc(45, 1), "R4 fb applied", fb_div_word, enc(45, 1));
    chk(out_div_word == enc(10, 0), "R4 out applied", out_div_word, enc(10, 0));
    chk(relock_start && !lock_o, "R6 pulse and unlock", {relock_start, lock_o}, 32'h2);
    @(negedge clk);
    chk(!relock_start, "R6 pulse single", relock_start, 0);
    repeat (RELOCK - 2) @(negedge clk);
    chk(!lock_o, "R6 still relocking", lock_o, 0);
    @(negedge clk);
    chk(lock_o, "R6 lock returns", lock_o, 1);
    v = 1'b0;
    rd_chk(12'h004, enc(45, 1), "R1 R4 read fb");
  endtask

  task automatic t_commit_from_in;
    wr(12'h004, enc(54, 1));
    wr(12'h000, enc(2, 0));
    chk(fb_div_word == enc(54, 1) && in_div_word == enc(2, 0), "R4 commit via in slot",
        fb_div_word, enc(54, 1));
    chk(out_div_word == enc(10, 0), "R4 out kept", out_div_word, enc(10, 0));
    wait_settle();
  endtask

  task automatic t_reserved;
    wr(12'h008, 32'hFFFF_8000 | enc(6, 0));
    chk(out_div_word == enc(6, 0), "R2 pad ignored", out_div_word, enc(6, 0));
    rd_chk(12'h008, enc(6, 0), "R2 pad reads zero");
    wr(12'h008, enc(1, 0));
    chk(out_div_word[13] && out_div_word[12] && out_div_word[5:0] == 6'd1 &&
        out_div_word[11:6] == 6'd0, "R2 bypass/edge/low fields", out_div_word, 32'h3001);
    wait_settle();
  endtask

  task automatic t_error;
    wr(12'h000, 32'h0000_00C0);
    chk(error_o, "R7 zero low flags error", error_o, 1);
    rd_chk(STAT, 32'h2, "R5 R7 status err no lock");
    wr(12'h004, enc(30, 1));
    chk(error_o, "R7 err held without commit", error_o, 1);
    wr(12'h000, enc(4, 0));
    chk(!error_o, "R7 err cleared", error_o, 0);
    wr(12'h000, 32'h0000_2000);
    chk(!error_o, "R7 bypass zero ok", error_o, 0);
    wait_settle();
  endtask

  task automatic t_unmapped;
    logic [31:0] keep_in, keep_fb, keep_out;
    keep_in = in_div_word; keep_fb = fb_div_word; keep_out = out_div_word;
    wr(12'h00C, 32'h0000_0123);
    chk(!relock_start && lock_o, "R1 unmapped no commit", {relock_start, lock_o}, 32'h1);
    rd_chk(12'h00C, 32'h0, "R1 unmapped reads zero");
    wr(12'h006, 32'h0000_0041);
    chk(in_div_word == keep_in && fb_div_word == keep_fb && out_div_word == keep_out,
        "R1 misaligned ignored", fb_div_word, keep_fb);
    wr(STAT, 32'hFFFF_FFFC);
    rd_chk(STAT, 32'h1, "R5 status write ignored");
    pll_lock_in = 1'b0;
    @(negedge clk);
    chk(!lock_o, "R6 follows lock input", lock_o, 0);
    rd_chk(STAT, 32'h0, "R5 status unlocked");
    pll_lock_in = 1'b1;
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    pll_lock_in = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_staged();
    t_commit_from_in();
    t_reserved();
    t_error();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule